// File: doc/BRIEF.md
# Soft-Start and Overcurrent Policy Sequencer

This block runs on the controller side of a switching power supply. It produces the gate-timing pulse train that a power-stage driver follows. The switching period is fixed by a configuration input, and the block picks the width of every pulse. Once the initialization-done and supply-in-range inputs are both high, the pulse width starts small. It then climbs in programmed steps until it reaches a steady-state ceiling, and that ceiling bounds the volt-seconds applied to the transformer.

The driver raises a current-limit flag when it truncates a pulse. The sequencer treats every switching period in which the flag is seen as one overcurrent event and acts on it under a selectable policy:

- latch off on the first event;
- tolerate a set number of events, then latch off;
- enter a hiccup cycle, either at once or after a set number of events.

During a hiccup cycle no pulses are sent for a programmed number of periods. After that the soft-start begins again. A run of fault-free periods forgives earlier events.

The block also outputs a current-limit threshold code. The code stays at a high setting for the first part of each run and then falls to a lower setting. Measurement, volt-second arithmetic and register access are handled elsewhere and arrive here as plain configuration inputs.

Top module: `softstart_ocp_seq`

## Requirements
- R1: No pulse is issued and `running_o` stays low unless both `init_done` and `supply_ok` are high. If either one falls during a run, `running_o` and `pulse_o` are low from the next cycle on. A later enable starts again from the first soft-start step.
- R2: A switching period lasts `period_cfg` clock cycles, with values below 2 treated as 2. Periods follow each other back to back from the cycle after enable. Each pulse starts in the first cycle of its period and stays high for a number of consecutive cycles equal to the current duty value.
- R3: The first period of a run has a width of min(`duty_step`, `duty_max`). The width grows by `duty_step` after every `step_every` periods, and a `step_every` of 0 acts as 1. So period k of a run has a width of min(`duty_step`·(1+⌊k/M⌋), `duty_max`).
- R4: The width never rises above `duty_max`. Once it reaches `duty_max` it stays there.
- R5: A width change takes effect only at a period boundary. If `duty_max` is lowered partway through a period, that period keeps its width and the next period uses the new ceiling.
- R6: While running, a high `clf` forces `pulse_o` low in the same cycle and for the rest of that period. Each period with `clf` seen counts as one event.
- R7: With `policy` 0 (and also with the unused code 3), the first event stops all pulses and sets `latched_o` from the next period on. Only reset clears this.
- R8: With `policy` 1, events up to `fault_limit` are tolerated while pulses keep running. Event number `fault_limit`+1 latches the block off as in R7.
- R9: With `policy` 2, event number `fault_limit`+1 sets `hiccup_o` and stops pulses for `hiccup_off` periods, with 0 treated as 1. A limit of 0 means hiccup on the first event. `clf` is ignored while in hiccup.
- R10: When a hiccup ends, the run restarts at the first soft-start step with the event count cleared. The threshold profile also restarts.
- R11: After `clean_reset` consecutive fault-free periods the event count returns to zero. A value of 0 disables this forgiveness.
- R12: `ilim_code_o` equals `ilim_hi` during the first `ilim_hold` periods of each run and equals `ilim_lo` afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Controller initialization complete |
| supply_ok | input | 1 | Monitored voltages are in range |
| period_cfg | input | PW | Switching period in clock cycles |
| duty_max | input | PW | Steady-state pulse width ceiling |
| duty_step | input | PW | Soft-start width increment |
| step_every | input | CW | Periods between increments |
| policy | input | 2 | 0 latch, 1 count then latch, 2 hiccup, 3 as latch |
| fault_limit | input | CW | Events tolerated before acting |
| hiccup_off | input | CW | Hiccup off-time in periods |
| clean_reset | input | CW | Fault-free periods that clear the event count |
| ilim_hold | input | CW | Periods at the high threshold per run |
| ilim_hi | input | TW | High threshold code |
| ilim_lo | input | TW | Low threshold code |
| clf | input | 1 | Current-limit flag from the driver |
| pulse_o | output | 1 | Pulse train to the driver |
| ilim_code_o | output | TW | Selected current-limit threshold code |
| running_o | output | 1 | Pulses are being generated |
| hiccup_o | output | 1 | Hiccup off-time in progress |
| latched_o | output | 1 | Latched off until reset |

## Verification
The hardest case to reach from the ports is a restart out of hiccup where it matters that the event count was cleared. The test has to place faults in exact periods: one set to trigger the hiccup, then a single fault after the restart that must not trigger a second one. Only the bench's knowledge of period boundaries makes this possible. The bench counts clock cycles from the edge where enable is raised, so it knows where every period starts. It injects `clf` at chosen offsets inside chosen periods, and it reads the pulse width, the threshold code and the status flags period by period. The same alignment lets it apply a `duty_max` change partway through a period and check that the change waits for the boundary.

// File: rtl/ssq_pkg.sv
`timescale 1ns/1ps
package ssq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_HICCUP  = 2'd2,
    ST_LATCHED = 2'd3
  } ssq_state_e;

  typedef enum logic [1:0] {
    POL_LATCH  = 2'd0,
    POL_COUNT  = 2'd1,
    POL_HICCUP = 2'd2,
    POL_RSVD   = 2'd3
  } ssq_policy_e;

endpackage

// File: rtl/ssq_period_timer.sv
`timescale 1ns/1ps
module ssq_period_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period_cfg,
  output logic [PW-1:0] pcnt,
  output logic          period_end
);

  // Index of the final cycle in a period; periods shorter than 2 are widened.
  function automatic logic [PW-1:0] last_tick(input logic [PW-1:0] cfg);
    return (cfg < PW'(2)) ? PW'(1) : cfg - PW'(1);
  endfunction

  assign period_end = run && (pcnt >= last_tick(period_cfg));

  always_ff @(posedge clk) begin
    if (!rst_n)                pcnt <= '0;
    else if (!run || period_end) pcnt <= '0;
    else                       pcnt <= pcnt + PW'(1);
  end

  // R2: every run starts at the first cycle of a period
  a_r2_start_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> pcnt == '0);

endmodule

// File: rtl/ssq_duty_ramp.sv
`timescale 1ns/1ps
module ssq_duty_ramp #(
  parameter int PW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          active,
  input  logic          period_end,
  input  logic [PW-1:0] duty_step,
  input  logic [CW-1:0] step_every,
  input  logic [PW-1:0] duty_max,
  output logic [PW-1:0] duty,
  output logic          step_due
);

  logic [CW-1:0] mcnt;
  logic [CW-1:0] every_eff;

  function automatic logic [PW-1:0] clamp_to(input logic [PW-1:0] cur,
                                             input logic [PW-1:0] cap);
    return (cur > cap) ? cap : cur;
  endfunction

  function automatic logic [PW-1:0] raise(input logic [PW-1:0] cur,
                                          input logic [PW-1:0] step,
                                          input logic [PW-1:0] cap);
    logic [PW:0] sum;
    sum = (PW+1)'(cur) + (PW+1)'(step);
    return (sum > (PW+1)'(cap)) ? cap : sum[PW-1:0];
  endfunction

  assign every_eff = (step_every == '0) ? CW'(1) : step_every;
  assign step_due  = ((CW+1)'(mcnt) + (CW+1)'(1)) >= (CW+1)'(every_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty <= '0;
      mcnt <= '0;
    end else if (restart) begin
      duty <= clamp_to(duty_step, duty_max);
      mcnt <= '0;
    end else if (active && period_end) begin
      if (step_due) begin
        mcnt <= '0;
        duty <= raise(duty, duty_step, duty_max);
      end else begin
        mcnt <= mcnt + CW'(1);
        duty <= clamp_to(duty, duty_max);
      end
    end
  end

  // R5: width only moves at a period boundary or a restart
  a_r5_duty_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !restart) |=> $stable(duty));

  // R4: after a boundary update the width respects the ceiling in force
  a_r4_duty_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (active && period_end && !restart) |=> duty <= $past(duty_max));

endmodule

// File: rtl/ssq_fault_policy.sv
`timescale 1ns/1ps
module ssq_fault_policy
  import ssq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          clf,
  input  logic          period_end,
  input  ssq_policy_e   policy,
  input  logic [CW-1:0] fault_limit,
  input  logic [CW-1:0] hiccup_off,
  input  logic [CW-1:0] clean_reset,
  output ssq_state_e    state,
  output logic          restart,
  output logic          kill,
  output logic          fault_in_period
);

  logic [CW-1:0] evt_cnt, clean_cnt, off_cnt;
  logic [CW-1:0] evt_next, off_eff;
  logic          trip, go_hiccup, go_latch, off_done, clean_hit, in_run;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + CW'(1);
  endfunction

  function automatic logic reaches(input logic [CW-1:0] cnt,
                                   input logic [CW-1:0] lim);
    return ((CW+1)'(cnt) + (CW+1)'(1)) >= (CW+1)'(lim);
  endfunction

  assign in_run          = (state == ST_RUN);
  assign fault_in_period = in_run && (kill || clf);
  assign evt_next        = sat_inc(evt_cnt);
  assign trip            = (policy == POL_LATCH) || (policy == POL_RSVD) ||
                           (evt_next > fault_limit);
  assign go_hiccup       = period_end && fault_in_period && trip && (policy == POL_HICCUP);
  assign go_latch        = period_end && fault_in_period && trip && (policy != POL_HICCUP);
  assign off_eff         = (hiccup_off == '0) ? CW'(1) : hiccup_off;
  assign off_done        = (state == ST_HICCUP) && period_end && reaches(off_cnt, off_eff);
  assign clean_hit       = (clean_reset != '0) && reaches(clean_cnt, clean_reset);
  assign restart         = enable && ((state == ST_IDLE) || off_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      evt_cnt   <= '0;
      clean_cnt <= '0;
      off_cnt   <= '0;
      kill      <= 1'b0;
    end else if (state == ST_LATCHED) begin
      kill <= 1'b0;
    end else if (!enable) begin
      state     <= ST_IDLE;
      evt_cnt   <= '0;
      clean_cnt <= '0;
      off_cnt   <= '0;
      kill      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state     <= ST_RUN;
          evt_cnt   <= '0;
          clean_cnt <= '0;
          kill      <= 1'b0;
        end
        ST_RUN: begin
          kill <= period_end ? 1'b0 : (kill || clf);
          if (period_end) begin
            if (fault_in_period) begin
              evt_cnt   <= evt_next;
              clean_cnt <= '0;
              if (go_hiccup) begin
                state   <= ST_HICCUP;
                off_cnt <= '0;
              end else if (go_latch) begin
                state <= ST_LATCHED;
              end
            end else if (clean_hit) begin
              evt_cnt   <= '0;
              clean_cnt <= '0;
            end else begin
              clean_cnt <= sat_inc(clean_cnt);
            end
          end
        end
        ST_HICCUP: begin
          kill <= 1'b0;
          if (period_end) begin
            if (off_done) begin
              state     <= ST_RUN;
              evt_cnt   <= '0;
              clean_cnt <= '0;
              off_cnt   <= '0;
            end else begin
              off_cnt <= off_cnt + CW'(1);
            end
          end
        end
        default: state <= ST_LATCHED;
      endcase
    end
  end

  // R7: latch-off is permanent until reset
  a_r7_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCHED) |=> (state == ST_LATCHED));

  // R9: hiccup is only entered from a faulted period at its boundary
  a_r9_hiccup_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !(period_end && fault_in_period)) |=> (state != ST_HICCUP));

  // R10: hiccup is left only at a period boundary
  a_r10_resume_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HICCUP && !period_end) |=> (state != ST_RUN));

  // R8: counting policy never latches while the count is within the limit
  a_r8_tolerate_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_COUNT && in_run && enable && evt_next <= fault_limit)
      |=> (state != ST_LATCHED));

endmodule

// File: rtl/ssq_ilim_profile.sv
`timescale 1ns/1ps
module ssq_ilim_profile #(
  parameter int CW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          active,
  input  logic          period_end,
  input  logic [CW-1:0] ilim_hold,
  input  logic [TW-1:0] ilim_hi,
  input  logic [TW-1:0] ilim_lo,
  output logic [TW-1:0] code
);

  logic [CW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                                    hcnt <= '0;
    else if (restart)                              hcnt <= '0;
    else if (active && period_end && hcnt != '1)   hcnt <= hcnt + CW'(1);
  end

  assign code = (hcnt < ilim_hold) ? ilim_hi : ilim_lo;

  // R12: the profile position advances only at a boundary or a restart
  a_r12_profile_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !restart) |=> $stable(hcnt));

endmodule

// File: rtl/softstart_ocp_seq.sv
`timescale 1ns/1ps
module softstart_ocp_seq
  import ssq_pkg::*;
#(
  parameter int PW = 8,
  parameter int CW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_done,
  input  logic          supply_ok,
  input  logic [PW-1:0] period_cfg,
  input  logic [PW-1:0] duty_max,
  input  logic [PW-1:0] duty_step,
  input  logic [CW-1:0] step_every,
  input  logic [1:0]    policy,
  input  logic [CW-1:0] fault_limit,
  input  logic [CW-1:0] hiccup_off,
  input  logic [CW-1:0] clean_reset,
  input  logic [CW-1:0] ilim_hold,
  input  logic [TW-1:0] ilim_hi,
  input  logic [TW-1:0] ilim_lo,
  input  logic          clf,
  output logic          pulse_o,
  output logic [TW-1:0] ilim_code_o,
  output logic          running_o,
  output logic          hiccup_o,
  output logic          latched_o
);

  ssq_state_e    state;
  logic          enable, restart, kill, fault_in_period, period_end, step_due, timer_run;
  logic [PW-1:0] pcnt, duty;

  assign enable    = init_done && supply_ok;
  assign running_o = (state == ST_RUN);
  assign hiccup_o  = (state == ST_HICCUP);
  assign latched_o = (state == ST_LATCHED);
  assign timer_run = running_o || hiccup_o;

  ssq_period_timer #(.PW(PW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (timer_run),
    .period_cfg (period_cfg),
    .pcnt       (pcnt),
    .period_end (period_end)
  );

  ssq_fault_policy #(.CW(CW)) u_policy (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .clf             (clf),
    .period_end      (period_end),
    .policy          (ssq_policy_e'(policy)),
    .fault_limit     (fault_limit),
    .hiccup_off      (hiccup_off),
    .clean_reset     (clean_reset),
    .state           (state),
    .restart         (restart),
    .kill            (kill),
    .fault_in_period (fault_in_period)
  );

  ssq_duty_ramp #(.PW(PW), .CW(CW)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .active     (running_o),
    .period_end (period_end),
    .duty_step  (duty_step),
    .step_every (step_every),
    .duty_max   (duty_max),
    .duty       (duty),
    .step_due   (step_due)
  );

  ssq_ilim_profile #(.CW(CW), .TW(TW)) u_ilim (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .active     (running_o),
    .period_end (period_end),
    .ilim_hold  (ilim_hold),
    .ilim_hi    (ilim_hi),
    .ilim_lo    (ilim_lo),
    .code       (ilim_code_o)
  );

  assign pulse_o = running_o && (pcnt < duty) && !kill && !clf;

  // R1: a run is only ever in progress after enable was present
  a_r1_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> $past(init_done && supply_ok));

  // R6: a flag inside a period silences the rest of that period
  a_r6_clf_truncates: assert property (@(posedge clk) disable iff (!rst_n)
    (clf && running_o && !period_end) |=> !pulse_o);

endmodule

// File: tb/softstart_ocp_seq_test.sv
`timescale 1ns/1ps
module softstart_ocp_seq_test;
  localparam int PW = 8;
  localparam int CW = 8;
  localparam int TW = 4;
  localparam int P  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, init_done, supply_ok, clf;
  logic [PW-1:0] period_cfg, duty_max, duty_step;
  logic [CW-1:0] step_every, fault_limit, hiccup_off, clean_reset, ilim_hold;
  logic [1:0]    policy;
  logic [TW-1:0] ilim_hi, ilim_lo;
  logic          pulse_o, running_o, hiccup_o, latched_o;
  logic [TW-1:0] ilim_code_o;

  softstart_ocp_seq #(.PW(PW), .CW(CW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .supply_ok(supply_ok),
    .period_cfg(period_cfg), .duty_max(duty_max), .duty_step(duty_step),
    .step_every(step_every), .policy(policy), .fault_limit(fault_limit),
    .hiccup_off(hiccup_off), .clean_reset(clean_reset), .ilim_hold(ilim_hold),
    .ilim_hi(ilim_hi), .ilim_lo(ilim_lo), .clf(clf), .pulse_o(pulse_o),
    .ilim_code_o(ilim_code_o), .running_o(running_o), .hiccup_o(hiccup_o),
    .latched_o(latched_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // per-period observations
  int w, first_p, run_s, hic_s, lat_s, code_s;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  function automatic int exp_w(input int k, input int s, input int m, input int mx);
    int v;
    v = s * (1 + k / ((m == 0) ? 1 : m));
    return (v > mx) ? mx : v;
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0; init_done = 1'b0; supply_ok = 1'b0; clf = 1'b0;
    period_cfg = PW'(P); duty_max = PW'(6); duty_step = PW'(2); step_every = CW'(1);
    policy = 2'd0; fault_limit = '0; hiccup_off = CW'(1); clean_reset = '0;
    ilim_hold = CW'(2); ilim_hi = TW'(12); ilim_lo = TW'(5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_run();
    @(negedge clk);
    init_done = 1'b1;
    supply_ok = 1'b1;
  endtask

  // One switching period: optional flag at offset fo, optional ceiling change at offset co.
  task automatic period(input int fo, input int co, input int newmax);
    w = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      clf = (i == fo);
      if (i == co) duty_max = PW'(newmax);
      #1;
      if (i == 0) begin
        first_p = int'(pulse_o); run_s = int'(running_o); hic_s = int'(hiccup_o);
        lat_s = int'(latched_o); code_s = int'(ilim_code_o);
      end
      w += int'(pulse_o);
    end
  endtask

  task automatic t_reset_and_gate();
    int seen;
    apply_reset();
    #1;
    check("R1 reset pulse", int'(pulse_o), 0);
    check("R1 reset running", int'(running_o), 0);
    check("R7 reset latched", int'(latched_o), 0);
    check("R9 reset hiccup", int'(hiccup_o), 0);
    check("R12 reset code", int'(ilim_code_o), 12);
    seen = 0;
    init_done = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      seen += int'(pulse_o) + int'(running_o);
    end
    check("R1 init only, supply low", seen, 0);
    init_done = 1'b0; supply_ok = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      seen += int'(pulse_o) + int'(running_o);
    end
    check("R1 supply only, init low", seen, 0);
  endtask

  task automatic t_ramp();
    apply_reset();
    duty_step = PW'(2); step_every = CW'(2); duty_max = PW'(5);
    start_run();
    for (int k = 0; k < 8; k++) begin
      period(-1, -1, 0);
      check($sformatf("R3 R4 width period %0d", k), w, exp_w(k, 2, 2, 5));
      check($sformatf("R2 pulse at period start %0d", k), first_p, 1);
    end
    period(-1, 3, 3);
    check("R5 width kept in change period", w, 5);
    period(-1, -1, 0);
    check("R5 new ceiling next period", w, 3);
    period(-1, -1, 0);
    check("R4 held at ceiling", w, 3);
  endtask

  task automatic t_latch();
    apply_reset();
    policy = 2'd0; duty_step = PW'(3); duty_max = PW'(6);
    start_run();
    period(-1, -1, 0);
    check("R3 first width", w, 3);
    period(1, -1, 0);
    check("R6 truncated width", w, 1);
    for (int k = 0; k < 3; k++) begin
      period(-1, -1, 0);
      check("R7 latched flag", lat_s, 1);
      check("R7 no pulse after latch", w, 0);
    end
    apply_reset();
    #1;
    check("R7 cleared by reset", int'(latched_o), 0);
  endtask

  task automatic t_count();
    apply_reset();
    policy = 2'd1; fault_limit = CW'(2);
    start_run();
    period(-1, -1, 0);
    period(0, -1, 0);
    period(0, -1, 0);
    check("R8 running after two events", run_s, 1);
    period(0, -1, 0);
    check("R8 not latched at limit", lat_s, 0);
    period(-1, -1, 0);
    check("R8 latched after limit+1", lat_s, 1);
    check("R8 no pulse", w, 0);
  endtask

  task automatic t_hiccup_now();
    apply_reset();
    policy = 2'd2; fault_limit = '0; hiccup_off = CW'(3); ilim_hold = CW'(2);
    start_run();
    period(-1, -1, 0);
    check("R12 code high period 0", code_s, 12);
    period(-1, -1, 0);
    check("R3 width period 1", w, 4);
    period(0, -1, 0);
    check("R12 code low after hold", code_s, 5);
    for (int k = 0; k < 3; k++) begin
      period((k == 1) ? 2 : -1, -1, 0);
      check("R9 hiccup flag", hic_s, 1);
      check("R9 no pulse in hiccup", w, 0);
    end
    period(-1, -1, 0);
    check("R10 restart running", run_s, 1);
    check("R10 hiccup clear", hic_s, 0);
    check("R10 first step width", w, 2);
    check("R10 profile restarted", code_s, 12);
    period(-1, -1, 0);
    check("R10 ramp resumes", w, 4);
  endtask

  task automatic t_hiccup_count();
    apply_reset();
    policy = 2'd2; fault_limit = CW'(1); hiccup_off = CW'(2);
    start_run();
    period(-1, -1, 0);
    period(0, -1, 0);
    period(0, -1, 0);
    check("R9 first event tolerated", hic_s, 0);
    period(-1, -1, 0);
    check("R9 hiccup after count", hic_s, 1);
    period(-1, -1, 0);
    check("R9 hiccup second period", hic_s, 1);
    period(-1, -1, 0);
    check("R10 restart width", w, 2);
    period(0, -1, 0);
    period(-1, -1, 0);
    check("R10 count cleared, no hiccup", hic_s, 0);
    check("R10 width after single event", w, 6);
  endtask

  task automatic t_clean();
    apply_reset();
    policy = 2'd1; fault_limit = CW'(1); clean_reset = CW'(2);
    start_run();
    period(-1, -1, 0);
    period(0, -1, 0);
    period(-1, -1, 0);
    period(-1, -1, 0);
    period(0, -1, 0);
    period(0, -1, 0);
    check("R11 forgiven count, not latched", lat_s, 0);
    period(-1, -1, 0);
    check("R11 latched after two fresh events", lat_s, 1);
    apply_reset();
    policy = 2'd1; fault_limit = CW'(1); clean_reset = CW'(3);
    start_run();
    period(-1, -1, 0);
    period(0, -1, 0);
    period(-1, -1, 0);
    period(-1, -1, 0);
    period(0, -1, 0);
    period(-1, -1, 0);
    check("R11 too few clean periods, latched", lat_s, 1);
  endtask

  task automatic t_profile_and_drop();
    apply_reset();
    ilim_hold = CW'(3);
    start_run();
    for (int k = 0; k < 5; k++) begin
      period(-1, -1, 0);
      check($sformatf("R12 code period %0d", k), code_s, (k < 3) ? 12 : 5);
    end
    @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk); #1;
    check("R1 drop stops running", int'(running_o), 0);
    check("R1 drop stops pulse", int'(pulse_o), 0);
    @(negedge clk);
    supply_ok = 1'b1;
    period(-1, -1, 0);
    check("R1 re-enable restarts ramp", w, 2);
    check("R12 re-enable profile high", code_s, 12);
  endtask

  initial begin
    t_reset_and_gate();
    t_ramp();
    t_latch();
    t_count();
    t_hiccup_now();
    t_hiccup_count();
    t_clean();
    t_profile_and_drop();
    summary();
    $finish;
  end

endmodule